// File: doc/BRIEF.md
# Triggered Waveform Vector Sequencer

This block drives one channel of a waveform synthesizer from a table of segment descriptors. It walks through its own slice of the table, one descriptor at a time. For each descriptor it presents the amplitude, frequency and phase parameters to a downstream accumulator engine and pulses a start strobe. It then holds those values for the segment's length before it moves to the next descriptor. The table lives in an external synchronous-read memory. The sequencer supplies the read address and takes the registered descriptor word one cycle later. It fetches ahead so that segments follow each other with no gap.

Playback can be gated by an external trigger, which passes through a one-entry queue. After reset the sequencer always waits for a trigger, and it also waits at any descriptor that has its trigger flag set. While it waits in normal mode, it issues a start with both amplitude terms forced to zero, and it issues a second, real start when the trigger arrives. In hold mode it starts the segment unmuted at once and keeps phase continuity. The trigger then only releases the segment timer, and no second start is issued. The table slice comes from the channel number and from whether the partner channel of the pair also runs from the table.

Top module: `segment_sequencer`

## Requirements
- R1: Each descriptor word is packed, MSB first, as: last flag (bit 93), trigger flag (bit 92), sample count (12 bits, 91:80), amplitude start (16 bits, 79:64), amplitude step (16 bits, 63:48), frequency (32 bits, 47:16) and phase (16 bits, 15:0). Descriptors play in ascending address order, starting at the slice base.
- R2: After a descriptor whose last flag is 1 finishes, playback continues at the slice base.
- R3: After the descriptor at the top address of the slice finishes, playback continues at the slice base, even with its last flag at 0.
- R4: Slice map, as base..top. Channel 0: 0..127 alone, 0..63 paired. Channel 2: 0..127 alone, 64..127 paired. Channel 1: 128..383 alone, 128..255 paired. Channel 3: 128..383 alone, 256..383 paired. During reset the read address equals the base.
- R5: After reset the first descriptor waits for a trigger, whatever its trigger flag.
- R6: A descriptor with its trigger flag set waits if no trigger is queued or present on the input in its decision cycle. In normal mode it then issues a start with both amplitude outputs at zero, and its real frequency and phase.
- R7: In normal mode, a trigger seen during a wait produces a real start on the next cycle.
- R8: The start strobe is a single-cycle pulse. The phase-load strobe equals the start strobe when hold mode is off and stays low when hold mode is on.
- R9: In hold mode a waiting descriptor starts at once with real amplitudes. The trigger issues no further start and begins the segment's timing.
- R10: A real start (or a hold-mode release) and the next descriptor's start are count+32 cycles apart.
- R11: The queue keeps one trigger. Further triggers are dropped while it is full. A consumed trigger, or one queued ahead of a descriptor that needs it, lets that descriptor start without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_sel | input | 2 | Channel number, 0 to 3 |
| partner_vec | input | 1 | Partner channel of the pair also plays from the table |
| hold_en | input | 1 | Hold mode: unmuted, phase-continuous waiting |
| trig_in | input | 1 | Trigger event, one per high cycle |
| rd_addr | output | 9 | Table read address |
| rd_data | input | 94 | Descriptor word, valid the cycle after the address |
| seg_start | output | 1 | Segment start strobe |
| phase_load | output | 1 | Phase accumulator load strobe |
| amp_start_o | output | 16 | Amplitude start value |
| amp_step_o | output | 16 | Amplitude step value |
| freq_o | output | 32 | Frequency value |
| phase_o | output | 16 | Phase value |

## Verification
If the address state is wrong, the next start carries the frequency and phase of the wrong descriptor. That shows up at the first segment boundary after the fault. A segment timer that is off shifts every later start away from its count+32 spacing, so the error grows with each segment. A wrong wait or trigger-queue state shows at the next descriptor that needs a trigger: its start is muted when it should be real, real when it should be muted, or missing or doubled in hold mode.

// File: rtl/seg_seq_pkg.sv
package seg_seq_pkg;
  localparam int CNT_W   = 12;
  localparam int AMP_W   = 16;
  localparam int FRQ_W   = 32;
  localparam int PHS_W   = 16;
  localparam int DUR_PAD = 32;
  localparam int DUR_W   = CNT_W + 1;

  typedef struct packed {
    logic             last;
    logic             trig;
    logic [CNT_W-1:0] cnt;
    logic [AMP_W-1:0] amp0;
    logic [AMP_W-1:0] ampd;
    logic [FRQ_W-1:0] frq;
    logic [PHS_W-1:0] phs;
  } seg_desc_t;

  localparam int DESC_W = $bits(seg_desc_t);

  typedef enum logic [1:0] {ST_ADDR, ST_LOAD, ST_WAIT, ST_PLAY} seq_state_t;
endpackage

// File: rtl/seg_region.sv
module seg_region #(
  parameter int ADDR_W = 9,
  parameter int SLICE  = 64
) (
  input  logic [1:0]        chan_sel,
  input  logic              partner_vec,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] top_o
);
  localparam int EVEN_BASE = 0;
  localparam int EVEN_SPAN = 2 * SLICE;
  localparam int ODD_BASE  = 2 * SLICE;
  localparam int ODD_SPAN  = 4 * SLICE;

  logic [ADDR_W-1:0] pair_base, span, half, off, len;

  always_comb begin
    pair_base = chan_sel[0] ? ADDR_W'(ODD_BASE) : ADDR_W'(EVEN_BASE);
    span      = chan_sel[0] ? ADDR_W'(ODD_SPAN) : ADDR_W'(EVEN_SPAN);
    half      = span >> 1;
    off       = (partner_vec && chan_sel[1]) ? half : '0;
    len       = partner_vec ? half : span;
    base_o    = pair_base + off;
    top_o     = pair_base + off + len - ADDR_W'(1);
  end
endmodule

// File: rtl/seg_trigq.sv
module seg_trigq (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic consume,
  output logic avail
);
  logic pend;

  assign avail = pend | trig_in;

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (consume) pend <= 1'b0;
    else              pend <= pend | trig_in;
  end
endmodule

// File: rtl/seg_timer.sv
module seg_timer #(
  parameter int DUR_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  output logic             near_fetch,
  output logic             near_load
);
  localparam int FETCH_AT = 2;
  localparam int LOAD_AT  = 1;

  logic [DUR_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst)              rem <= '0;
    else if (load)        rem <= load_val;
    else if (rem != '0)   rem <= rem - DUR_W'(1);
  end

  assign near_fetch = (rem == DUR_W'(FETCH_AT));
  assign near_load  = (rem == DUR_W'(LOAD_AT));
endmodule

// File: rtl/segment_sequencer.sv
module segment_sequencer
  import seg_seq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SLICE  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        chan_sel,
  input  logic              partner_vec,
  input  logic              hold_en,
  input  logic              trig_in,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DESC_W-1:0] rd_data,
  output logic              seg_start,
  output logic              phase_load,
  output logic [AMP_W-1:0]  amp_start_o,
  output logic [AMP_W-1:0]  amp_step_o,
  output logic [FRQ_W-1:0]  freq_o,
  output logic [PHS_W-1:0]  phase_o
);
  seq_state_t        state;
  seg_desc_t         cur, desc_in;
  logic              boot_pend;
  logic [ADDR_W-1:0] base_a, top_a, next_idx;
  logic              trig_avail, consume, tmr_load, near_fetch, near_load;
  logic              need_trig, go;
  logic [CNT_W-1:0]  dur_src;
  logic [DUR_W-1:0]  tmr_val;

  assign desc_in = seg_desc_t'(rd_data);

  seg_region #(.ADDR_W(ADDR_W), .SLICE(SLICE)) region_i (
    .chan_sel(chan_sel), .partner_vec(partner_vec), .base_o(base_a), .top_o(top_a));

  seg_trigq trigq_i (
    .clk(clk), .rst(rst), .trig_in(trig_in), .consume(consume), .avail(trig_avail));

  seg_timer #(.DUR_W(DUR_W)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .near_fetch(near_fetch), .near_load(near_load));

  assign next_idx = (cur.last || rd_addr == top_a) ? base_a : rd_addr + ADDR_W'(1);

  always_comb begin
    need_trig = boot_pend | desc_in.trig;
    go        = !need_trig || trig_avail;
    dur_src   = (state == ST_LOAD) ? desc_in.cnt : cur.cnt;
    tmr_val   = {1'b0, dur_src} + DUR_W'(DUR_PAD - 1);
    consume   = 1'b0;
    tmr_load  = 1'b0;
    case (state)
      ST_LOAD: if (go) begin
        consume  = need_trig;
        tmr_load = 1'b1;
      end
      ST_WAIT: if (trig_avail) begin
        consume  = 1'b1;
        tmr_load = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_ADDR;
      rd_addr     <= base_a;
      cur         <= '0;
      boot_pend   <= 1'b1;
      seg_start   <= 1'b0;
      phase_load  <= 1'b0;
      amp_start_o <= '0;
      amp_step_o  <= '0;
      freq_o      <= '0;
      phase_o     <= '0;
    end else begin
      seg_start  <= 1'b0;
      phase_load <= 1'b0;
      case (state)
        ST_ADDR: state <= ST_LOAD;
        ST_LOAD: begin
          cur        <= desc_in;
          seg_start  <= 1'b1;
          phase_load <= !hold_en;
          freq_o     <= desc_in.frq;
          phase_o    <= desc_in.phs;
          if (go || hold_en) begin
            amp_start_o <= desc_in.amp0;
            amp_step_o  <= desc_in.ampd;
          end else begin
            amp_start_o <= '0;
            amp_step_o  <= '0;
          end
          if (go) begin
            boot_pend <= 1'b0;
            state     <= ST_PLAY;
          end else begin
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: if (trig_avail) begin
          boot_pend <= 1'b0;
          state     <= ST_PLAY;
          if (!hold_en) begin
            seg_start   <= 1'b1;
            phase_load  <= 1'b1;
            amp_start_o <= cur.amp0;
            amp_step_o  <= cur.ampd;
          end
        end
        ST_PLAY: begin
          if (near_fetch) rd_addr <= next_idx;
          if (near_load)  state   <= ST_LOAD;
        end
        default: state <= ST_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/seg_seq_chk.sv
module seg_seq_chk #(
  parameter int ADDR_W = 9,
  parameter int SLICE  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        chan_sel,
  input logic              partner_vec,
  input logic              hold_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              seg_start,
  input logic              phase_load
);
  int lo, hi;

  always_comb begin
    case (chan_sel)
      2'd0:    begin lo = 0;         hi = partner_vec ? SLICE - 1     : 2 * SLICE - 1; end
      2'd2:    begin lo = partner_vec ? SLICE : 0;          hi = 2 * SLICE - 1;   end
      2'd1:    begin lo = 2 * SLICE; hi = partner_vec ? 4 * SLICE - 1 : 6 * SLICE - 1; end
      default: begin lo = partner_vec ? 4 * SLICE : 2 * SLICE; hi = 6 * SLICE - 1; end
    endcase
  end

  a_r4_addr_in_region: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) >= lo && int'(rd_addr) <= hi));

  a_r8_load_needs_start: assert property (@(posedge clk) disable iff (rst)
    phase_load |-> seg_start);

  a_r8_load_low_in_hold: assert property (@(posedge clk) disable iff (rst)
    phase_load |-> !hold_en);

  a_r8_load_with_start: assert property (@(posedge clk) disable iff (rst)
    (seg_start && !hold_en) |-> phase_load);

  a_r9_hold_single_start: assert property (@(posedge clk) disable iff (rst)
    (seg_start && hold_en) |=> !seg_start);
endmodule

bind segment_sequencer seg_seq_chk #(.ADDR_W(ADDR_W), .SLICE(SLICE)) chk_i (
  .clk(clk), .rst(rst), .chan_sel(chan_sel), .partner_vec(partner_vec),
  .hold_en(hold_en), .rd_addr(rd_addr), .seg_start(seg_start), .phase_load(phase_load));

// File: tb/segment_sequencer_tb_top.sv
`timescale 1ns/1ps
module segment_sequencer_tb_top;
  import seg_seq_pkg::*;

  localparam int ADDR_W = 9;
  localparam int DEPTH  = 384;
  localparam int MAXEV  = 256;

  logic clk = 0, rst = 1;
  logic [1:0] chan_sel = 0;
  logic partner_vec = 0, hold_en = 0, trig_in = 0;
  logic [ADDR_W-1:0] rd_addr;
  logic [DESC_W-1:0] rd_data;
  logic seg_start, phase_load;
  logic [AMP_W-1:0] amp_start_o, amp_step_o;
  logic [FRQ_W-1:0] freq_o;
  logic [PHS_W-1:0] phase_o;

  seg_desc_t mem [DEPTH];

  segment_sequencer dut_i (
    .clk(clk), .rst(rst), .chan_sel(chan_sel), .partner_vec(partner_vec),
    .hold_en(hold_en), .trig_in(trig_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .seg_start(seg_start), .phase_load(phase_load), .amp_start_o(amp_start_o),
    .amp_step_o(amp_step_o), .freq_o(freq_o), .phase_o(phase_o));

  always #2.5 clk = ~clk;

  always @(posedge clk) rd_data <= mem[rd_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_ev = 0;
  int ev_cyc [MAXEV];
  logic [FRQ_W-1:0] ev_frq [MAXEV];
  logic [PHS_W-1:0] ev_phs [MAXEV];
  logic [AMP_W-1:0] ev_a0 [MAXEV];
  logic [AMP_W-1:0] ev_ad [MAXEV];
  logic ev_pl [MAXEV];

  always @(negedge clk) begin
    if (rst) n_ev = 0;
    else if (seg_start && n_ev < MAXEV) begin
      ev_cyc[n_ev] = cyc; ev_frq[n_ev] = freq_o; ev_phs[n_ev] = phase_o;
      ev_a0[n_ev] = amp_start_o; ev_ad[n_ev] = amp_step_o; ev_pl[n_ev] = phase_load;
      n_ev = n_ev + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  function automatic int dur(int v);
    return int'(mem[v].cnt) + DUR_PAD;
  endfunction

  function automatic logic [AMP_W-1:0] exp_amp(int v, bit step, bit muted);
    if (muted) return '0;
    return step ? mem[v].ampd : mem[v].amp0;
  endfunction

  task automatic put(int a, bit last, bit trg, int cnt);
    mem[a] = '{last: last, trig: trg, cnt: CNT_W'(cnt),
               amp0: AMP_W'($urandom) | AMP_W'(1), ampd: AMP_W'($urandom) | AMP_W'(1),
               frq: FRQ_W'(a) + FRQ_W'(32'h1000), phs: PHS_W'($urandom)};
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ev(int i, int exp_cyc, int v, bit muted, bit pl, string req);
    n_chk++;
    if (i >= n_ev) begin
      n_fail++;
      $display("FAIL %s start #%0d missing: actual %0d starts expected > %0d", req, i, n_ev, i);
    end else if ((exp_cyc >= 0 && ev_cyc[i] != exp_cyc) || ev_frq[i] != mem[v].frq ||
                 ev_phs[i] != mem[v].phs || ev_a0[i] != exp_amp(v, 0, muted) ||
                 ev_ad[i] != exp_amp(v, 1, muted) || ev_pl[i] != pl) begin
      n_fail++;
      $display("FAIL %s start #%0d: actual cyc=%0d frq=%0h a0=%0h ad=%0h ph=%0h pl=%0b expected cyc=%0d frq=%0h a0=%0h ad=%0h ph=%0h pl=%0b",
               req, i, ev_cyc[i], ev_frq[i], ev_a0[i], ev_ad[i], ev_phs[i], ev_pl[i],
               exp_cyc, mem[v].frq, exp_amp(v, 0, muted), exp_amp(v, 1, muted), mem[v].phs, pl);
    end
  endtask

  task automatic do_reset(logic [1:0] ch, bit partner, bit hold, int exp_base);
    @(negedge clk);
    rst = 1; trig_in = 0; chan_sel = ch; partner_vec = partner; hold_en = hold;
    repeat (3) @(negedge clk);
    chk(rd_addr == ADDR_W'(exp_base), "R4", "reset base address", int'(rd_addr), exp_base);
    chk(!seg_start && !phase_load, "R8", "strobes low in reset", int'(seg_start), 0);
    rst = 0;
  endtask

  task automatic pulse_trig(output int k);
    @(negedge clk);
    trig_in = 1; k = cyc;
    @(negedge clk);
    trig_in = 0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    int k, t0, e1, e2, e3, e4;
    void'($urandom(32'd20250601));
    for (int a = 0; a < DEPTH; a++) put(a, 0, 0, 0);

    // Scenario A: slice base 0, boot stall, last-flag wrap, random counts
    for (int rep = 0; rep < 3; rep++) begin
      put(0, 0, 0, $urandom % 40); put(1, 0, 0, $urandom % 40);
      put(2, 1, 0, $urandom % 40); put(3, 0, 0, 5);
      do_reset(2'd0, 0, 0, 0);
      repeat (6) @(negedge clk);
      chk_ev(0, -1, 0, 1, 1, "R5_R6 boot start muted");
      repeat ($urandom % 7) @(negedge clk);
      pulse_trig(k);
      e1 = k + 1; e2 = e1 + dur(0); e3 = e2 + dur(1); e4 = e3 + dur(2);
      wait_until(e4 + 3);
      chk_ev(1, e1, 0, 0, 1, "R7 real start after trigger");
      chk_ev(2, e2, 1, 0, 1, "R1_R10 ascending and spacing");
      chk_ev(3, e3, 2, 0, 1, "R1_R10 third descriptor");
      chk_ev(4, e4, 0, 0, 1, "R2 last flag wraps");
      chk(n_ev == 5, "R2", "start count", n_ev, 5);
    end

    // Scenario B: channel 1 paired, trigger flag and one-deep queue
    put(128, 0, 0, $urandom % 30); put(129, 0, 1, $urandom % 30); put(130, 1, 0, $urandom % 30);
    do_reset(2'd1, 1, 0, 128);
    pulse_trig(k);
    repeat (4) @(negedge clk);
    chk_ev(0, -1, 128, 0, 1, "R11 early trigger avoids boot wait");
    t0 = (n_ev > 0) ? ev_cyc[0] : cyc;
    wait_until(t0 + 3); pulse_trig(k);
    wait_until(t0 + 6); pulse_trig(k);
    e1 = t0 + dur(128); e2 = e1 + dur(129); e3 = e2 + dur(130); e4 = e3 + dur(128);
    wait_until(e4 + 5);
    chk_ev(1, e1, 129, 0, 1, "R11 queued trigger consumed");
    chk_ev(2, e2, 130, 0, 1, "R10 spacing");
    chk_ev(3, e3, 128, 0, 1, "R2 wrap to base 128");
    chk_ev(4, e4, 129, 1, 1, "R11_R6 second trigger dropped, muted");
    pulse_trig(k);
    e1 = k + 1; e2 = e1 + dur(129);
    wait_until(e2 + 2);
    chk_ev(5, e1, 129, 0, 1, "R7 restart after trigger");
    chk_ev(6, e2, 130, 0, 1, "R10 spacing after restart");
    chk(n_ev == 7, "R7", "start count", n_ev, 7);

    // Scenario C: channel 3 paired, hold mode
    put(256, 0, 0, $urandom % 30); put(257, 1, 1, $urandom % 30);
    do_reset(2'd3, 1, 1, 256);
    repeat (6) @(negedge clk);
    chk_ev(0, -1, 256, 0, 0, "R9 hold boot start unmuted");
    repeat (10) @(negedge clk);
    pulse_trig(k);
    e1 = k + 1 + dur(256);
    wait_until(e1 - 1);
    chk(n_ev == 1, "R9", "no second start on trigger", n_ev, 1);
    wait_until(e1 + 10);
    chk_ev(1, e1, 257, 0, 0, "R9_R10 timing from release");
    pulse_trig(k);
    e2 = k + 1 + dur(257);
    wait_until(e2 + 2);
    chk_ev(2, e2, 256, 0, 0, "R2_R9 wrap after release");
    chk(n_ev == 3, "R9", "start count", n_ev, 3);

    // Scenario D: channel 2 paired, top-of-slice wrap
    do_reset(2'd2, 0, 0, 0);
    for (int a = 64; a < 128; a++) put(a, 0, 0, 0);
    do_reset(2'd2, 1, 0, 64);
    pulse_trig(k);
    repeat (4) @(negedge clk);
    t0 = (n_ev > 0) ? ev_cyc[0] : cyc;
    wait_until(t0 + 65 * 32 + 2);
    chk_ev(0, t0, 64, 0, 1, "R4 channel 2 paired base");
    chk_ev(1, t0 + 32, 65, 0, 1, "R1 next address");
    chk_ev(63, t0 + 63 * 32, 127, 0, 1, "R3 top address");
    chk_ev(64, t0 + 64 * 32, 64, 0, 1, "R3 wrap at top");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule